// File: doc/BRIEF.md
# Incremental Vector Draw Engine

This block draws one straight-line segment on a beam display by stepping an X and a Y position counter. A start pulse, accepted only while the engine is idle, loads the start position, the per-axis rate components, the per-axis direction bits, the segment length and the color. Drawing then begins. Each cycle in which the draw state and the external vector clock strobe are both high counts as one draw clock.

On every draw clock, each axis adds its rate component into its own accumulator. The carry out of that accumulator moves the axis position by one count, up or down as the direction bit selects. Over the segment, the ratio of the two rates sets the slope of the line. The same draw clock also decrements a length counter. When that counter runs out, drawing stops and a one-cycle done pulse is issued.

The beam is blanked while the engine is idle and whenever the position lies outside a parameterised visible window. The blank flag and the color word pass through a delay line together, with a selectable tap that matches the lag of the deflection stage.

Top module: `vdraw_engine`

## Requirements
- R1: After reset, x_o and y_o are 0, blank_o is 1, color_o is 0 and done_o is 0.
- R2: A start_i sampled high while idle loads x0_i/y0_i into the position counters, and loads the rates, direction bits, length and color. A nonzero length enters the drawing state on the same edge.
- R3: On each draw clock (drawing and vclk_i high), each axis adds its 8-bit rate into an 8-bit accumulator that is cleared at start. A carry out moves that axis by exactly one count. After a segment of length L, the axis has moved floor(L*rate/256) counts, and the position never changes in a cycle without a draw clock.
- R4: A direction bit of 1 makes its axis count up; 0 makes it count down. Positions are 10 bits and wrap modulo 1024.
- R5: The length counter decrements only on draw clocks. done_o is high for exactly one cycle, the cycle after the edge that carries the L-th draw clock, and drawing ends on that edge.
- R6: A length of 0 raises done_o in the cycle after the start edge, makes no steps and leaves the beam blanked.
- R7: start_i while drawing is ignored: the position path, the length and the color of the current segment are unaffected.
- R8: With tap select 0, blank_o is 1 exactly when the engine is idle or the position is off-screen. Off-screen means x < XMIN, x > XMAX, y < YMIN or y > YMAX (defaults 64 and 959 on both axes).
- R9: Tap select k (0 to 3) delays both blank and color by k clock cycles.
- R10: color_o presents the color latched at the accepted start, after the selected tap delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a segment (taken only when idle) |
| vclk_i | input | 1 | Vector clock strobe; gated with the draw state to form the draw clock |
| x_rate_i | input | 8 | X rate component of the angle |
| y_rate_i | input | 8 | Y rate component of the angle |
| x_up_i | input | 1 | X direction, 1 = up |
| y_up_i | input | 1 | Y direction, 1 = up |
| len_i | input | 12 | Segment length in draw clocks |
| x0_i | input | 10 | Start X position |
| y0_i | input | 10 | Start Y position |
| color_i | input | 9 | Color word |
| tap_sel_i | input | 2 | Blank/color delay tap |
| x_o | output | 10 | X position |
| y_o | output | 10 | Y position |
| blank_o | output | 1 | Beam blank, delayed |
| color_o | output | 9 | Color, delayed |
| done_o | output | 1 | Segment complete pulse |

## Verification
A corrupted accumulator or a wrong carry shows up at the end of the segment as a final x_o or y_o that is off from the closed-form displacement. A wrong direction or a bad wrap shows up the same way. A length counter that counts the wrong cycles moves done_o away from the exact cycle after the last draw clock, and the bench checks every cycle against that timing. A bad window compare or a wrong tap shows up within a cycle or two, as a blank_o that disagrees with the window computed from the observed position, or a blank edge that is not exactly k cycles after done.

// File: rtl/vdraw_pkg.sv
package vdraw_pkg;
  localparam int POS_W = 10;
  localparam int NAX   = 2;
  typedef logic [POS_W-1:0] pos_t;
endpackage

// File: rtl/vdraw_rate_mult.sv
module vdraw_rate_mult #(
  parameter int AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          en_i,
  input  logic [AW-1:0] rate_i,
  output logic          step_o
);
  logic [AW-1:0] acc_q;
  logic [AW:0]   sum;

  assign sum    = {1'b0, acc_q} + {1'b0, rate_i};
  assign step_o = en_i & sum[AW];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_q <= '0;
    else if (clr_i) acc_q <= '0;
    else if (en_i)  acc_q <= sum[AW-1:0];
  end
endmodule

// File: rtl/vdraw_axis.sv
module vdraw_axis
  import vdraw_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  pos_t start_i,
  input  logic step_i,
  input  logic up_i,
  output pos_t pos_o
);
  pos_t pos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pos_q <= '0;
    else if (load_i)  pos_q <= start_i;
    else if (step_i)  pos_q <= up_i ? pos_q + pos_t'(1) : pos_q - pos_t'(1);
  end

  assign pos_o = pos_q;
endmodule

// File: rtl/vdraw_tap_delay.sv
module vdraw_tap_delay #(
  parameter int          W       = 10,
  parameter int          TAPS    = 4,
  parameter logic [W-1:0] RST_VAL = '0,
  localparam int         DEPTH   = TAPS - 1,
  localparam int         SEL_W   = (TAPS > 1) ? $clog2(TAPS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [W-1:0]     d_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [W-1:0]     q_o
);
  logic [W-1:0] stg_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[i] <= RST_VAL;
      else if (i == 0) stg_q[i] <= d_i;
      else stg_q[i] <= stg_q[(i > 0) ? i-1 : 0];
    end
  end

  always_comb begin
    q_o = d_i;
    for (int k = 1; k <= DEPTH; k++)
      if (sel_i == SEL_W'(k)) q_o = stg_q[k-1];
  end
endmodule

// File: rtl/vdraw_engine.sv
module vdraw_engine
  import vdraw_pkg::*;
#(
  parameter int AW    = 8,
  parameter int LEN_W = 12,
  parameter int COL_W = 9,
  parameter int TAPS  = 4,
  parameter int XMIN  = 64,
  parameter int XMAX  = 959,
  parameter int YMIN  = 64,
  parameter int YMAX  = 959,
  localparam int SEL_W = (TAPS > 1) ? $clog2(TAPS) : 1,
  localparam int PW    = COL_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             vclk_i,
  input  logic [AW-1:0]    x_rate_i,
  input  logic [AW-1:0]    y_rate_i,
  input  logic             x_up_i,
  input  logic             y_up_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [POS_W-1:0] x0_i,
  input  logic [POS_W-1:0] y0_i,
  input  logic [COL_W-1:0] color_i,
  input  logic [SEL_W-1:0] tap_sel_i,
  output logic [POS_W-1:0] x_o,
  output logic [POS_W-1:0] y_o,
  output logic             blank_o,
  output logic [COL_W-1:0] color_o,
  output logic             done_o
);
  logic             draw_q, done_q, accept, dclk;
  logic [LEN_W-1:0] len_q;
  logic [COL_W-1:0] color_q;
  logic [AW-1:0]    rate_in [NAX];
  logic [AW-1:0]    rate_q  [NAX];
  logic [NAX-1:0]   up_in, up_q, step;
  pos_t             org [NAX];
  pos_t             pos [NAX];
  logic             off_scr, blank_raw;

  assign accept = start_i & ~draw_q;
  assign dclk   = draw_q & vclk_i;

  assign rate_in[0] = x_rate_i;
  assign rate_in[1] = y_rate_i;
  assign up_in      = {y_up_i, x_up_i};
  assign org[0]     = x0_i;
  assign org[1]     = y0_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      draw_q  <= 1'b0;
      done_q  <= 1'b0;
      len_q   <= '0;
      color_q <= '0;
      up_q    <= '0;
      for (int a = 0; a < NAX; a++) rate_q[a] <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        len_q   <= len_i;
        draw_q  <= (len_i != '0);
        done_q  <= (len_i == '0);
        color_q <= color_i;
        up_q    <= up_in;
        for (int a = 0; a < NAX; a++) rate_q[a] <= rate_in[a];
      end else if (dclk) begin
        len_q <= len_q - LEN_W'(1);
        if (len_q == LEN_W'(1)) begin
          draw_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  for (genvar a = 0; a < NAX; a++) begin : g_axis
    vdraw_rate_mult #(.AW(AW)) u_rm (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (accept),
      .en_i   (dclk),
      .rate_i (rate_q[a]),
      .step_o (step[a])
    );
    vdraw_axis u_ax (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .load_i  (accept),
      .start_i (org[a]),
      .step_i  (step[a]),
      .up_i    (up_q[a]),
      .pos_o   (pos[a])
    );
  end

  assign x_o = pos[0];
  assign y_o = pos[1];

  assign off_scr = (int'(x_o) < XMIN) || (int'(x_o) > XMAX) ||
                   (int'(y_o) < YMIN) || (int'(y_o) > YMAX);
  assign blank_raw = ~draw_q | off_scr;

  vdraw_tap_delay #(
    .W       (PW),
    .TAPS    (TAPS),
    .RST_VAL ({1'b1, {COL_W{1'b0}}})
  ) u_dly (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({blank_raw, color_q}),
    .sel_i  (tap_sel_i),
    .q_o    ({blank_o, color_o})
  );

  assign done_o = done_q;

  AST_NO_STEP_WO_DCLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dclk && !accept) |=> ($stable(x_o) && $stable(y_o))); // R3
  AST_LEN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (draw_q && !vclk_i) |=> $stable(len_q)); // R5
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R5
  AST_ZERO_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && len_i == '0) |=> (done_o && !draw_q)); // R6
  AST_BUSY_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && draw_q) |=> $stable(color_q)); // R7
  AST_STEP_UNIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (draw_q && !accept) |=> ((x_o - $past(x_o)) inside {10'd0, 10'd1, 10'h3FF})); // R3
endmodule

// File: tb/sim_vdraw_engine.sv
`timescale 1ns/1ps
module sim_vdraw_engine;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        start = 1'b0, vclk = 1'b0;
  logic [7:0]  xr = '0, yr = '0;
  logic        xu = 1'b0, yu = 1'b0;
  logic [11:0] len = '0;
  logic [9:0]  x0 = '0, y0 = '0;
  logic [8:0]  col = '0;
  logic [1:0]  tap = '0;
  logic [9:0]  xo, yo;
  logic        blank, done;
  logic [8:0]  colo;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  vdraw_engine u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .vclk_i(vclk),
    .x_rate_i(xr), .y_rate_i(yr), .x_up_i(xu), .y_up_i(yu), .len_i(len),
    .x0_i(x0), .y0_i(y0), .color_i(col), .tap_sel_i(tap),
    .x_o(xo), .y_o(yo), .blank_o(blank), .color_o(colo), .done_o(done)
  );

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  function automatic bit off_f(input int x, input int y);
    return x < 64 || x > 959 || y < 64 || y > 959;
  endfunction

  function automatic int end_pos(input int p0, input int rate, input bit up, input int l);
    int d = (l * rate) >> 8;
    return up ? (p0 + d) & 1023 : (p0 - d) & 1023;
  endfunction

  task automatic run_seg(input int sx, input int sy, input int rx, input int ry,
                         input bit ux, input bit uy, input int l, input int c,
                         input int k, input bit mid);
    int sent = 0;
    bit mid_done = 0;
    int ex = end_pos(sx, rx, ux, l);
    int ey = end_pos(sy, ry, uy, l);
    @(negedge clk);
    x0 = 10'(sx); y0 = 10'(sy); xr = 8'(rx); yr = 8'(ry); xu = ux; yu = uy;
    len = 12'(l); col = 9'(c); tap = 2'(k); start = 1'b1; vclk = 1'b0;
    @(negedge clk);
    start = 1'b0;
    if (l == 0) begin
      chk(done == 1'b1, "R6 done", int'(done), 1);
      chk(blank == 1'b1, "R6 blank", int'(blank), 1);
      chk(xo == 10'(sx) && yo == 10'(sy), "R6 no step", int'(xo), sx);
      @(negedge clk);
      chk(done == 1'b0, "R5 done width", int'(done), 0);
    end else begin
      chk(xo == 10'(sx) && yo == 10'(sy), "R2 load", int'(xo), sx);
      while (sent < l) begin
        chk(done == 1'b0, "R5 early done", int'(done), 0);
        if (k == 0)
          chk(blank == off_f(xo, yo), "R8 blank", int'(blank), int'(off_f(xo, yo)));
        if (mid && !mid_done && sent == l/2) begin
          start = 1'b1; x0 = x0 ^ 10'h155; col = ~col; mid_done = 1;
        end else start = 1'b0;
        vclk = ($urandom % 3) != 0;
        if (vclk) sent++;
        @(negedge clk);
      end
      start = 1'b0; vclk = 1'b0;
      chk(done == 1'b1, "R5 done timing", int'(done), 1);
      chk(xo == 10'(ex), mid ? "R7 x path" : (ux ? "R3 x up" : "R4 x down"), int'(xo), ex);
      chk(yo == 10'(ey), mid ? "R7 y path" : "R3 y", int'(yo), ey);
      if (k > 0 && !off_f(sx, sy) && !off_f(ex, ey) && l >= 4) begin
        for (int j = 0; j <= k; j++) begin
          chk(blank == (j == k), "R9 tap delay", int'(blank), int'(j == k));
          @(negedge clk);
        end
      end
      @(negedge clk);
      chk(done == 1'b0, "R5 done width", int'(done), 0);
    end
    repeat (4) @(negedge clk);
    chk(colo == 9'(c), mid ? "R7 color" : "R10 color", int'(colo), c);
    chk(blank == 1'b1, "R8 idle blank", int'(blank), 1);
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    chk(xo == 0 && yo == 0, "R1 pos", int'(xo), 0);
    chk(blank == 1'b1, "R1 blank", int'(blank), 1);
    chk(colo == 0, "R1 color", int'(colo), 0);
    chk(done == 1'b0, "R1 done", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // directed corners
    run_seg(300, 400, 90, 200, 1, 0, 0, 9'h1A5, 0, 0);   // R6 zero length
    run_seg(10, 500, 128, 40, 1, 1, 60, 9'h0F0, 0, 0);   // R8 offscreen start
    run_seg(1020, 3, 255, 255, 1, 0, 20, 9'h111, 0, 0);  // R4 wrap both ways
    run_seg(512, 512, 0, 255, 0, 1, 50, 9'h0AA, 0, 0);   // R3 zero rate
    run_seg(500, 500, 77, 160, 1, 0, 90, 9'h133, 0, 1);  // R7 start while drawing
    run_seg(512, 512, 64, 32, 1, 1, 40, 9'h055, 1, 0);   // R9 tap 1
    run_seg(512, 512, 200, 9, 0, 1, 40, 9'h0C3, 2, 0);   // R9 tap 2
    run_seg(512, 512, 33, 250, 1, 0, 40, 9'h1FE, 3, 0);  // R9 tap 3
    for (int i = 0; i < 40; i++) begin
      int k = $urandom % 4;
      if (k != 0)
        run_seg(412 + $urandom % 200, 412 + $urandom % 200, $urandom % 256, $urandom % 256,
                $urandom % 2, $urandom % 2, 4 + $urandom % 200, $urandom % 512, k, 0);
      else
        run_seg($urandom % 1024, $urandom % 1024, $urandom % 256, $urandom % 256,
                $urandom % 2, $urandom % 2, $urandom % 300, $urandom % 512, 0, (i % 5) == 0);
    end
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 8);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule